// File: doc/BRIEF.md
# Dual-Port MII Mode and Crossover Selector

This block sits between the data paths of two PHY cores and the two MAC-facing interfaces that serve them. One mode request field chooses how both ports present themselves: plain 4-bit MII, 2-bit RMII, or a reverse-MII repeater arrangement. In the repeater arrangement, the data a port receives from its line is sent out on the other port's line. All ports always share a single mode and a common clocking scheme.

Timing runs on one fast clock. Two enable inputs mark the 50 MHz and 25 MHz sample points. In RMII mode each port packs pairs of transmit dibits into nibbles for the PHY core, and splits each received nibble into two dibits for the MAC. In repeater mode, a path select chooses how the cross-connection is made. With the select at 1, the block makes the connection itself. With the select at 0, it passes data straight through and leaves the crossing to wiring on the board.

A mode controller holds the applied setting in one of three states:

- ST_MII (the reset state)
- ST_RMII
- ST_REV

It takes a new request only while every port is idle, meaning no transmit enable and no receive valid on either port. Each accepted change also clears the datapath registers. The ST_REV state flags port 0's transmit and receive clocks as inputs.

The transitions are:

- ST_MII to ST_RMII or ST_REV
- ST_RMII to ST_MII or ST_REV
- ST_REV to ST_MII or ST_RMII
- ST_REV to ST_REV, when only the path select changes

Every transition fires on the first clock edge where all ports are idle and the decoded request differs from the applied setting.

Top module: `mii_xconn_top`

## Requirements
- R1: After reset, mode_o is 2'b00, clk_in_o is all zero, and every transmit enable, receive valid and data output is low.
- R2: The request is decoded as follows: 2'b00 selects MII, 2'b01 selects RMII, 2'b11 selects reverse MII, and the reserved value 2'b10 selects MII. mode_o reports the applied setting with the same codes and never shows 2'b10.
- R3: A new mode or path select is taken only on a clock edge where all mac_txen_i and phy_rxdv_i bits are low. Otherwise the old setting is kept. The edge that takes the change also clears every datapath output to zero.
- R4: In MII mode, each edge with ce25_i high copies each port's mac_txen_i/mac_txd_i to phy_txen_o/phy_txd_o, and its phy_rxdv_i/phy_rxd_i to mac_rxdv_o/mac_rxd_o. Without ce25_i, the outputs hold.
- R5: In RMII mode, the transmit dibit is mac_txd_i bits [1:0], sampled on ce50_i edges while mac_txen_i is high.
  - The first dibit after mac_txen_i rises becomes nibble bits [1:0] and the second becomes bits [3:2]. The nibble appears on phy_txd_o, with phy_txen_o high, at the edge that takes the second dibit.
  - A ce50_i edge with mac_txen_i low drops phy_txen_o, clears phy_txd_o, and discards an unpaired dibit.
- R6: In RMII mode, a ce50_i edge with no half pending takes phy_rxd_i/phy_rxdv_i and shows the nibble's bits [1:0] on mac_rxd_o[1:0].
  - If phy_rxdv_i was high, the next ce50_i edge shows bits [3:2] with mac_rxdv_o still high.
  - mac_rxd_o[3:2] reads zero.
- R7: In reverse MII with path select 1, each ce25_i edge loads phy_txd_o/phy_txen_o of each port from the other port's phy_rxd_i/phy_rxdv_i. Both mac_rxdv_o and mac_rxd_o are driven to zero.
- R8: In reverse MII with path select 0, data passes straight through as in R4.
- R9: clk_in_o bit 0 is high exactly while the applied mode is reverse MII. clk_in_o bit 1 is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce50_i | input | 1 | 50 MHz sample enable |
| ce25_i | input | 1 | 25 MHz sample enable |
| mode_req_i | input | 2 | Requested interface mode |
| xsel_req_i | input | 1 | Repeater path select (1 internal, 0 board wiring) |
| mac_txen_i | input | 2 | Per-port transmit enable from MAC |
| mac_txd_i | input | 2x4 | Per-port transmit data from MAC |
| mac_rxdv_o | output | 2 | Per-port receive valid to MAC |
| mac_rxd_o | output | 2x4 | Per-port receive data to MAC |
| phy_txen_o | output | 2 | Per-port transmit enable to PHY core |
| phy_txd_o | output | 2x4 | Per-port transmit nibble to PHY core |
| phy_rxdv_i | input | 2 | Per-port receive valid from PHY core |
| phy_rxd_i | input | 2x4 | Per-port receive nibble from PHY core |
| mode_o | output | 2 | Applied mode |
| clk_in_o | output | 2 | Per-port flag: transmit/receive clocks are inputs |

## Verification
Results fall due at different points:

- **Mode changes:** appear on mode_o at the first clock edge where all ports are idle, regardless of the enables.
- **MII and repeater data:** appear one ce25_i edge after being driven.
- **RMII transmit nibbles:** appear at the ce50_i edge that takes the second dibit.
- **RMII receive dibits:** appear at the capturing ce50_i edge and then the next one.

The bench raises each enable for exactly one chosen edge. It drives inputs at the falling edge and samples at the next falling edge, so every check lands on the cycle after the edge that owns it. Some checks are made after edges with the enable low, to confirm the outputs hold.

// File: rtl/mii_xconn_pkg.sv
package mii_xconn_pkg;

    localparam int NPORT = 2;

    typedef enum logic [1:0] {
        ST_MII  = 2'b00,
        ST_RMII = 2'b01,
        ST_REV  = 2'b11
    } xc_mode_e;

    // Reserved request 2'b10 falls back to plain MII.
    function automatic xc_mode_e decode_mode(input logic [1:0] req);
        unique case (req)
            2'b01:   return ST_RMII;
            2'b11:   return ST_REV;
            default: return ST_MII;
        endcase
    endfunction

endpackage

// File: rtl/mii_xconn_ctrl.sv
module mii_xconn_ctrl
    import mii_xconn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req_i,
    input  logic       xsel_req_i,
    input  logic       quiet_i,
    output xc_mode_e   mode_o,
    output logic       xsel_o,
    output logic       flush_o
);

    xc_mode_e state_q, state_d;
    logic     xsel_q, xsel_d;
    xc_mode_e req_mode;

    assign req_mode = decode_mode(mode_req_i);

    // next-state and output process
    always_comb begin
        state_d = state_q;
        xsel_d  = xsel_q;
        flush_o = 1'b0;
        unique case (state_q)
            ST_MII, ST_RMII, ST_REV: begin
                if (quiet_i && ((req_mode != state_q) || (xsel_req_i != xsel_q))) begin
                    state_d = req_mode;
                    xsel_d  = xsel_req_i;
                    flush_o = 1'b1;
                end
            end
            default: begin
                state_d = ST_MII;
                flush_o = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MII;
            xsel_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            xsel_q  <= xsel_d;
        end
    end

    assign mode_o = state_q;
    assign xsel_o = xsel_q;

    // R3
    mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> $past(quiet_i));

    // R3
    xsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xsel_q) |-> $past(quiet_i));

    // R2
    rsvd_mii_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(quiet_i && (mode_req_i == 2'b10)) |-> (state_q == ST_MII));

endmodule

// File: rtl/rmii_tx_pack.sv
module rmii_tx_pack #(
    parameter int DW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               ce_i,
    input  logic               en_i,
    input  logic [DW/2-1:0]    dibit_i,
    output logic [DW-1:0]      nib_o,
    output logic               vld_o
);

    localparam int HW = DW / 2;

    logic          en_prev;
    logic          half;
    logic [HW-1:0] lo;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            en_prev <= 1'b0;
            half    <= 1'b0;
            lo      <= '0;
            nib_o   <= '0;
            vld_o   <= 1'b0;
        end else if (ce_i) begin
            en_prev <= en_i;
            if (!en_i) begin
                half  <= 1'b0;
                vld_o <= 1'b0;
                nib_o <= '0;
            end else if (!en_prev || !half) begin
                // rising enable always restarts on the low dibit
                lo   <= dibit_i;
                half <= 1'b1;
            end else begin
                nib_o <= {dibit_i, lo};
                vld_o <= 1'b1;
                half  <= 1'b0;
            end
        end
    end

    // R5
    pack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_i && en_i && !en_prev && !clr_i) |-> !$rose(vld_o));

endmodule

// File: rtl/rmii_rx_split.sv
module rmii_rx_split #(
    parameter int DW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               ce_i,
    input  logic               dv_i,
    input  logic [DW-1:0]      nib_i,
    output logic [DW/2-1:0]    dibit_o,
    output logic               dv_o
);

    localparam int HW = DW / 2;

    logic          phase;
    logic [HW-1:0] hold_hi;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            phase   <= 1'b0;
            hold_hi <= '0;
            dibit_o <= '0;
            dv_o    <= 1'b0;
        end else if (ce_i) begin
            if (!phase) begin
                dibit_o <= nib_i[HW-1:0];
                dv_o    <= dv_i;
                hold_hi <= nib_i[DW-1:HW];
                phase   <= dv_i;
            end else begin
                dibit_o <= hold_hi;
                dv_o    <= 1'b1;
                phase   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mii_xconn_lane.sv
module mii_xconn_lane
    import mii_xconn_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xc_mode_e      mode_i,
    input  logic          xsel_i,
    input  logic          flush_i,
    input  logic          ce50_i,
    input  logic          ce25_i,
    input  logic          mac_txen_i,
    input  logic [DW-1:0] mac_txd_i,
    input  logic          phy_rxdv_i,
    input  logic [DW-1:0] phy_rxd_i,
    input  logic          peer_rxdv_i,
    input  logic [DW-1:0] peer_rxd_i,
    output logic          phy_txen_o,
    output logic [DW-1:0] phy_txd_o,
    output logic          mac_rxdv_o,
    output logic [DW-1:0] mac_rxd_o
);

    localparam int HW = DW / 2;

    logic          tx_en_q, rx_dv_q;
    logic [DW-1:0] tx_d_q, rx_d_q;
    logic          rmii, rmii_clr;
    logic [DW-1:0] pk_nib;
    logic          pk_vld;
    logic [HW-1:0] sp_dibit;
    logic          sp_dv;

    assign rmii     = (mode_i == ST_RMII);
    assign rmii_clr = flush_i || !rmii;

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            tx_en_q <= 1'b0;
            tx_d_q  <= '0;
            rx_dv_q <= 1'b0;
            rx_d_q  <= '0;
        end else if (ce25_i && !rmii) begin
            if (mode_i == ST_REV && xsel_i) begin
                tx_en_q <= peer_rxdv_i;
                tx_d_q  <= peer_rxd_i;
                rx_dv_q <= 1'b0;
                rx_d_q  <= '0;
            end else begin
                tx_en_q <= mac_txen_i;
                tx_d_q  <= mac_txd_i;
                rx_dv_q <= phy_rxdv_i;
                rx_d_q  <= phy_rxd_i;
            end
        end
    end

    rmii_tx_pack #(.DW(DW)) pack_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rmii_clr),
        .ce_i    (ce50_i),
        .en_i    (mac_txen_i),
        .dibit_i (mac_txd_i[HW-1:0]),
        .nib_o   (pk_nib),
        .vld_o   (pk_vld)
    );

    rmii_rx_split #(.DW(DW)) split_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rmii_clr),
        .ce_i    (ce50_i),
        .dv_i    (phy_rxdv_i),
        .nib_i   (phy_rxd_i),
        .dibit_o (sp_dibit),
        .dv_o    (sp_dv)
    );

    always_comb begin
        if (rmii) begin
            phy_txen_o = pk_vld;
            phy_txd_o  = pk_nib;
            mac_rxdv_o = sp_dv;
            mac_rxd_o  = {{(DW-HW){1'b0}}, sp_dibit};
        end else begin
            phy_txen_o = tx_en_q;
            phy_txd_o  = tx_d_q;
            mac_rxdv_o = rx_dv_q;
            mac_rxd_o  = rx_d_q;
        end
    end

    // R7
    xover_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce25_i && mode_i == ST_REV && xsel_i && !flush_i)
        |=> (phy_txd_o == $past(peer_rxd_i)) && (phy_txen_o == $past(peer_rxdv_i)));

    // R7
    xover_mac_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce25_i && mode_i == ST_REV && xsel_i && !flush_i)
        |=> !mac_rxdv_o && (mac_rxd_o == '0));

endmodule

// File: rtl/mii_xconn_top.sv
module mii_xconn_top
    import mii_xconn_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce50_i,
    input  logic                       ce25_i,
    input  logic [1:0]                 mode_req_i,
    input  logic                       xsel_req_i,
    input  logic [NPORT-1:0]           mac_txen_i,
    input  logic [NPORT-1:0][DW-1:0]   mac_txd_i,
    output logic [NPORT-1:0]           mac_rxdv_o,
    output logic [NPORT-1:0][DW-1:0]   mac_rxd_o,
    output logic [NPORT-1:0]           phy_txen_o,
    output logic [NPORT-1:0][DW-1:0]   phy_txd_o,
    input  logic [NPORT-1:0]           phy_rxdv_i,
    input  logic [NPORT-1:0][DW-1:0]   phy_rxd_i,
    output logic [1:0]                 mode_o,
    output logic [NPORT-1:0]           clk_in_o
);

    xc_mode_e mode;
    logic     xsel, flush, quiet;

    assign quiet  = !(|mac_txen_i) && !(|phy_rxdv_i);
    assign mode_o = mode;

    mii_xconn_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_req_i (mode_req_i),
        .xsel_req_i (xsel_req_i),
        .quiet_i    (quiet),
        .mode_o     (mode),
        .xsel_o     (xsel),
        .flush_o    (flush)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        localparam int PEER = (p == 0) ? 1 : 0;

        assign clk_in_o[p] = (p == 0) && (mode == ST_REV);

        mii_xconn_lane #(.DW(DW)) lane_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (mode),
            .xsel_i      (xsel),
            .flush_i     (flush),
            .ce50_i      (ce50_i),
            .ce25_i      (ce25_i),
            .mac_txen_i  (mac_txen_i[p]),
            .mac_txd_i   (mac_txd_i[p]),
            .phy_rxdv_i  (phy_rxdv_i[p]),
            .phy_rxd_i   (phy_rxd_i[p]),
            .peer_rxdv_i (phy_rxdv_i[PEER]),
            .peer_rxd_i  (phy_rxd_i[PEER]),
            .phy_txen_o  (phy_txen_o[p]),
            .phy_txd_o   (phy_txd_o[p]),
            .mac_rxdv_o  (mac_rxdv_o[p]),
            .mac_rxd_o   (mac_rxd_o[p])
        );
    end

endmodule

// File: tb/mii_xconn_top_tb_top.sv
module mii_xconn_top_tb_top;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ce50, ce25;
    logic [1:0]      mode_req;
    logic            xsel_req;
    logic [1:0]      mac_txen;
    logic [1:0][3:0] mac_txd;
    logic [1:0]      mac_rxdv;
    logic [1:0][3:0] mac_rxd;
    logic [1:0]      phy_txen;
    logic [1:0][3:0] phy_txd;
    logic [1:0]      phy_rxdv;
    logic [1:0][3:0] phy_rxd;
    logic [1:0]      mode_o;
    logic [1:0]      clk_in;

    int  nvec  = 0;
    int  nfail = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    mii_xconn_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce50_i     (ce50),
        .ce25_i     (ce25),
        .mode_req_i (mode_req),
        .xsel_req_i (xsel_req),
        .mac_txen_i (mac_txen),
        .mac_txd_i  (mac_txd),
        .mac_rxdv_o (mac_rxdv),
        .mac_rxd_o  (mac_rxd),
        .phy_txen_o (phy_txen),
        .phy_txd_o  (phy_txd),
        .phy_rxdv_i (phy_rxdv),
        .phy_rxd_i  (phy_rxd),
        .mode_o     (mode_o),
        .clk_in_o   (clk_in)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input bit e50, input bit e25);
        ce50 = e50;
        ce25 = e25;
        @(posedge clk);
        @(negedge clk);
        ce50 = 1'b0;
        ce25 = 1'b0;
    endtask

    task automatic idle_inputs();
        mac_txen = '0; mac_txd = '0; phy_rxdv = '0; phy_rxd = '0;
    endtask

    task automatic t_reset();
        chk("R1 mode",   {6'd0, mode_o},   8'h00);
        chk("R1 clkin",  {6'd0, clk_in},   8'h00);
        chk("R1 txen",   {6'd0, phy_txen}, 8'h00);
        chk("R1 rxdv",   {6'd0, mac_rxdv}, 8'h00);
        chk("R1 txd",    phy_txd,          8'h00);
        chk("R1 rxd",    mac_rxd,          8'h00);
    endtask

    task automatic t_mii();
        mac_txd[0] = 4'hA; mac_txd[1] = 4'h5; mac_txen = 2'b11;
        phy_rxd[0] = 4'h3; phy_rxd[1] = 4'hC; phy_rxdv = 2'b11;
        tick(1, 0);
        chk("R4 hold without ce25", {6'd0, phy_txen}, 8'h00);
        tick(0, 1);
        chk("R4 tx data",  phy_txd,          8'h5A);
        chk("R4 tx en",    {6'd0, phy_txen}, 8'h03);
        chk("R4 rx data",  mac_rxd,          8'hC3);
        chk("R4 rx valid", {6'd0, mac_rxdv}, 8'h03);
        idle_inputs();
        tick(0, 1);
        chk("R4 idle", {6'd0, phy_txen}, 8'h00);
    endtask

    task automatic t_mode_gate();
        mode_req = 2'b01;
        mac_txen[0] = 1'b1;
        tick(0, 0);
        chk("R3 held while tx busy", {6'd0, mode_o}, 8'h00);
        mac_txen[0] = 1'b0; phy_rxdv[1] = 1'b1;
        tick(0, 0);
        chk("R3 held while rx busy", {6'd0, mode_o}, 8'h00);
        phy_rxdv[1] = 1'b0;
        tick(0, 0);
        chk("R2 R3 rmii taken", {6'd0, mode_o}, 8'h01);
    endtask

    task automatic t_rmii_tx();
        mac_txen[0] = 1'b1; mac_txd[0] = 4'b0001;
        tick(1, 0);
        chk("R5 no nibble after one dibit", {6'd0, phy_txen}, 8'h00);
        mac_txd[0] = 4'b0010;
        tick(0, 0);
        chk("R5 hold without ce50", {6'd0, phy_txen}, 8'h00);
        tick(1, 0);
        chk("R5 nibble order", phy_txd[0], 8'h09);
        chk("R5 nibble valid", {6'd0, phy_txen}, 8'h01);
        mac_txd[0] = 4'b0011;
        tick(1, 0);
        chk("R5 unpaired dibit keeps nibble", phy_txd[0], 8'h09);
        mac_txen[0] = 1'b0;
        tick(1, 0);
        chk("R5 enable drop", {6'd0, phy_txen}, 8'h00);
        chk("R5 data clear", phy_txd[0], 8'h00);
        mac_txen[0] = 1'b1; mac_txd[0] = 4'b0000;
        tick(1, 0);
        mac_txd[0] = 4'b0011;
        tick(1, 0);
        chk("R5 restart aligned", phy_txd[0], 8'h0C);
        idle_inputs();
        tick(1, 0);
    endtask

    task automatic t_rmii_rx();
        phy_rxdv[0] = 1'b1; phy_rxd[0] = 4'b1101;
        tick(1, 0);
        chk("R6 low dibit", mac_rxd[0], 8'h01);
        chk("R6 valid", {6'd0, mac_rxdv}, 8'h01);
        phy_rxd[0] = 4'b0000;
        tick(1, 0);
        chk("R6 high dibit", mac_rxd[0], 8'h03);
        phy_rxd[0] = 4'b0110;
        tick(1, 0);
        chk("R6 next low dibit", mac_rxd[0], 8'h02);
        phy_rxdv[0] = 1'b0;
        tick(1, 0);
        chk("R6 trailing high dibit", mac_rxd[0], 8'h01);
        chk("R6 trailing valid", {6'd0, mac_rxdv}, 8'h01);
        tick(1, 0);
        chk("R6 end of frame", {6'd0, mac_rxdv}, 8'h00);
    endtask

    task automatic t_rev_int();
        mode_req = 2'b11; xsel_req = 1'b1;
        tick(0, 0);
        chk("R2 rev taken", {6'd0, mode_o}, 8'h03);
        chk("R9 clk dir rev", {6'd0, clk_in}, 8'h01);
        phy_rxd[0] = 4'b0101; phy_rxd[1] = 4'b1010; phy_rxdv = 2'b11;
        mac_txd[0] = 4'hF;
        tick(0, 1);
        chk("R7 cross data", phy_txd, 8'h5A);
        chk("R7 cross valid", {6'd0, phy_txen}, 8'h03);
        chk("R7 mac rx quiet", {6'd0, mac_rxdv}, 8'h00);
    endtask

    task automatic t_rev_ext();
        idle_inputs();
        xsel_req = 1'b0;
        tick(0, 0);
        chk("R3 flush on change", {6'd0, phy_txen}, 8'h00);
        chk("R9 still rev", {6'd0, clk_in}, 8'h01);
        mac_txd[0] = 4'h3; mac_txen[0] = 1'b1;
        phy_rxd[0] = 4'hE; phy_rxdv[0] = 1'b1;
        tick(0, 1);
        chk("R8 tx pass", phy_txd[0], 8'h03);
        chk("R8 rx pass", mac_rxd[0], 8'h0E);
        idle_inputs();
        tick(0, 1);
    endtask

    task automatic t_reserved();
        mode_req = 2'b10;
        tick(0, 0);
        chk("R2 reserved as mii", {6'd0, mode_o}, 8'h00);
        chk("R9 clk dir mii", {6'd0, clk_in}, 8'h00);
        mac_txd[1] = 4'h6; mac_txen[1] = 1'b1;
        tick(0, 1);
        chk("R2 reserved passes data", phy_txd[1], 8'h06);
        idle_inputs();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        rst_n = 1'b0; ce50 = 1'b0; ce25 = 1'b0;
        mode_req = 2'b00; xsel_req = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mii();
        t_mode_gate();
        t_rmii_tx();
        t_rmii_rx();
        t_rev_int();
        t_rev_ext();
        t_reserved();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R1..all act=timeout exp=done");
            summary();
            $finish;
        end
    end

endmodule